// File: doc/BRIEF.md
# LIN Sync Field Bit-Time Meter

This block watches the synchronised receive line of a LIN node. It first looks for a break: a dominant (low) stretch of at least 13 nominal bit times, ended by a rising edge. Only then does it arm a measurement of the 0x55 sync byte that follows. The result is the bit period of the remote master, counted in local clock cycles. A baud-rate divider uses this value to cancel the local oscillator's error. Frame data, identifier parity and checksums are handled elsewhere.

The measurement is taken only between falling edges. The recessive (rising) edges come from a pull-up and are slow and variable. The dominant edges are driven, so they give much better timing. With its start bit, the sync byte has five falling edges spaced two bit times apart. The block adds up the four intervals between them (eight bit times) and divides by eight.

The result has no back-pressure. `bit_period_o` holds the last good value, and `bit_valid_o` marks the single cycle in which that value changes. A consumer that misses the strobe can still read the held period. No ready signal exists, because a measurement cannot be stalled while the line is moving.

Top module: `lin_sync_meter`

## Requirements
- R1: When the line has been sampled low for at least 13×`nom_bit_i` consecutive cycles and then returns high, `break_o` pulses high for exactly one cycle, one cycle after the first high sample. A shorter low stretch gives no pulse and arms no measurement.
- R2: A measurement is armed only by a `break_o` pulse. Falling edges that arrive without a preceding break produce neither `bit_valid_o` nor `sync_err_o`. A new break during a measurement restarts it.
- R3: After a break, the first falling edge starts the measurement. The next four falling edges end four intervals I1..I4, each counted in cycles between falling-edge samples. The reported period is floor((I1+I2+I3+I4)/8). Where the rising edges fall has no effect on the result.
- R4: If any of I2..I4 differs from I1 by more than floor(I1/8) cycles, `sync_err_o` is raised, no valid strobe is given, and the block returns to break hunting. A difference of exactly floor(I1/8) is accepted.
- R5: `sync_err_o` is a level. It stays high until the next `break_o` pulse, which clears it in the following cycle.
- R6: `bit_valid_o` is a single-cycle pulse. It appears in the same cycle that `bit_period_o` takes its new value, and never together with `sync_err_o`.
- R7: `bit_period_o` keeps its value through errors, timeouts and ignored edges. It changes only on a successful measurement.
- R8: If 2^CNT_W−1 cycles pass after a break, or after a falling edge, with no further falling edge, the measurement is abandoned. Later edges are ignored until a new break.
- R9: After reset, `bit_period_o`, `bit_valid_o`, `break_o` and `sync_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronised LIN receive line, low is dominant |
| nom_bit_i | input | CNT_W | Nominal bit period in cycles, used for the break threshold |
| bit_period_o | output | CNT_W | Last measured bit period in cycles |
| bit_valid_o | output | 1 | One-cycle strobe marking a new bit period |
| break_o | output | 1 | One-cycle strobe marking a valid break |
| sync_err_o | output | 1 | Sync byte failed the interval tolerance check |

## Verification
The bench sends sync bytes with a true bit time different from the nominal one. A design that averaged over the wrong number of intervals, or used the nominal value, would report the wrong period. It also stretches the low phases and shortens the high phases without moving any falling edge, so a design timing from rising edges gives a different answer. One interval is widened to exactly the tolerance limit and then one cycle past it, which exposes an off-by-one in the comparison. Short breaks, edges with no break before them, and a timeout after a break are each followed by a clean sync byte, so a design that arms too easily or never gives up produces an unexpected result.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_ARMED, ST_MEAS} meas_st_e;
  localparam int unsigned SYNC_INTERVALS = 4;
  localparam int unsigned AVG_SHIFT      = 3;
  localparam int unsigned BREAK_BITS     = 13;
endpackage

// File: rtl/lin_edge_det.sv
module lin_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
  assign rise_o = ~rx_q & rx_i;
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BREAK_BITS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] nom_i,
  output logic             brk_o
);
  localparam int unsigned LW = CNT_W + 4;

  logic [LW-1:0] low_cnt;
  logic [LW-1:0] limit;

  assign limit = LW'(nom_i) * LW'(BREAK_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      brk_o   <= 1'b0;
    end else begin
      if (!rx_i) begin
        if (low_cnt != {LW{1'b1}}) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
      brk_o <= rise_i && (low_cnt >= limit);
    end
  end

  // R1: a break strobe is never longer than one cycle
  a_r1_break_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> !brk_o);
endmodule

// File: rtl/lin_interval_ctr.sv
module lin_interval_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  assign sat_o = (cnt_o == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_o <= '0;
    else if (restart_i) cnt_o <= CNT_W'(1);
    else if (!sat_o)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] nom_bit_i,
  output logic [CNT_W-1:0] bit_period_o,
  output logic             bit_valid_o,
  output logic             break_o,
  output logic             sync_err_o
);
  import lin_sync_pkg::*;

  localparam int unsigned SUM_W = CNT_W + $clog2(SYNC_INTERVALS);
  localparam int unsigned IDX_W = $clog2(SYNC_INTERVALS);

  meas_st_e         st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] first_iv;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] total;
  logic             fall, rise, sat;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] diff;
  logic             out_of_tol;

  lin_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .fall_o(fall), .rise_o(rise)
  );

  lin_break_det #(.CNT_W(CNT_W), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rise_i(rise),
    .nom_i(nom_bit_i), .brk_o(break_o)
  );

  lin_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart_i(break_o | fall),
    .cnt_o(cnt), .sat_o(sat)
  );

  assign diff       = (cnt >= first_iv) ? (cnt - first_iv) : (first_iv - cnt);
  assign out_of_tol = diff > (first_iv >> 3);
  assign total      = sum + SUM_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_HUNT;
      idx          <= '0;
      first_iv     <= '0;
      sum          <= '0;
      bit_period_o <= '0;
      bit_valid_o  <= 1'b0;
      sync_err_o   <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      if (break_o) begin
        st         <= ST_ARMED;
        sync_err_o <= 1'b0;
      end else begin
        unique case (st)
          ST_HUNT: ;
          ST_ARMED: begin
            if (sat)       st <= ST_HUNT;
            else if (fall) begin
              st  <= ST_MEAS;
              idx <= '0;
            end
          end
          ST_MEAS: begin
            if (sat) st <= ST_HUNT;
            else if (fall) begin
              if (idx == '0) begin
                first_iv <= cnt;
                sum      <= SUM_W'(cnt);
                idx      <= idx + 1'b1;
              end else if (out_of_tol) begin
                sync_err_o <= 1'b1;
                st         <= ST_HUNT;
              end else if (idx == IDX_W'(SYNC_INTERVALS - 1)) begin
                bit_period_o <= CNT_W'(total >> AVG_SHIFT);
                bit_valid_o  <= 1'b1;
                st           <= ST_HUNT;
              end else begin
                sum <= total;
                idx <= idx + 1'b1;
              end
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  // R6: valid strobe lasts one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |=> !bit_valid_o);
  // R6: success and error never reported together
  a_r6_no_valid_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid_o && sync_err_o));
  // R7: the period only moves alongside the valid strobe
  a_r7_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_o |-> $stable(bit_period_o));
  // R2: entering the armed state requires a break strobe
  a_r2_arm_by_break: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && $past(st) != ST_ARMED) |-> $past(break_o));
  // R8: a saturated counter abandons the measurement
  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_HUNT && sat && !break_o) |=> st == ST_HUNT);
endmodule

// File: tb/test_lin_sync_meter.sv
module test_lin_sync_meter;
  localparam int CW  = 12;
  localparam int NOM = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic [CW-1:0] nom = CW'(NOM);
  logic [CW-1:0] period;
  logic          valid, brk, err;

  int tests = 0;
  int fails = 0;
  int brk_seen = 0;
  int brk_exp = 0;
  bit done = 1'b0;

  typedef struct { bit is_err; int per; string req; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  lin_sync_meter #(.CNT_W(CW)) i_lin_sync_meter (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .nom_bit_i(nom),
    .bit_period_o(period), .bit_valid_o(valid), .break_o(brk), .sync_err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit err_q = 1'b0;
  bit valid_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (brk) brk_seen++;
      if (valid_q) check(!valid, "R6 pulse width", int'(valid), 0);
      if (valid || (err && !err_q)) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", int'(valid ? period : 12'hfff), -1);
        end else begin
          item_t e;
          e = sb.pop_front();
          if (e.is_err) check(err && !valid, {e.req, " error"}, int'(valid), 0);
          else          check(valid && int'(period) == e.per, e.req, int'(period), e.per);
        end
      end
      err_q   = err;
      valid_q = valid;
    end
  end

  task automatic hold(input bit v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_break(input int low);
    hold(1'b0, low);
    hold(1'b1, NOM);
    if (low >= 13 * NOM) brk_exp++;
  endtask

  // 0x55 with start and stop; low bits +le, high bits -le; interval k widened by ext
  task automatic send_sync(input int t, input int le, input int k, input int ext);
    for (int i = 0; i < 10; i++) begin
      bit lvl;
      int len;
      lvl = (i % 2 == 1) || (i == 9);
      len = lvl ? (t - le) : (t + le);
      if (i == 9) len = t;
      if (i == 2 * k - 1) len = len + ext;
      hold(lvl, len);
    end
    hold(1'b1, 3 * t);
  endtask

  task automatic expect_ok(input int p, input string r);
    item_t e;
    e.is_err = 1'b0; e.per = p; e.req = r;
    sb.push_back(e);
  endtask

  task automatic expect_err(input string r);
    item_t e;
    e.is_err = 1'b1; e.per = 0; e.req = r;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(period == '0, "R9 period", int'(period), 0);
    check(!valid, "R9 valid", int'(valid), 0);
    check(!brk, "R9 break", int'(brk), 0);
    check(!err, "R9 err", int'(err), 0);
    rst_n = 1'b1;
    hold(1'b1, 20);

    send_break(1400); expect_ok(100, "R3 nominal");      send_sync(100, 0, 0, 0);
    send_break(1400); expect_ok(97,  "R3 slow clock");   send_sync(97, 0, 0, 0);
    send_break(1400); expect_ok(80,  "R3 asymmetric");   send_sync(80, 15, 0, 0);
    send_break(1400); expect_ok(103, "R4 at limit");     send_sync(100, 0, 3, 25);
    send_break(1400); expect_err("R4 beyond limit");     send_sync(100, 0, 3, 26);
    check(err, "R5 err held", int'(err), 1);
    check(int'(period) == 103, "R7 hold after error", int'(period), 103);
    send_break(1400);
    check(!err, "R5 err cleared by break", int'(err), 0);
    expect_ok(100, "R3 after error"); send_sync(100, 0, 0, 0);

    send_break(1200); send_sync(100, 0, 0, 0);
    check(int'(period) == 100, "R1 short break ignored", int'(period), 100);
    send_sync(100, 0, 0, 0);
    check(int'(period) == 100, "R2 no break ignored", int'(period), 100);

    send_break(1400); hold(1'b1, 4200); send_sync(100, 0, 0, 0);
    check(int'(period) == 100, "R8 timeout", int'(period), 100);
    send_break(1400); expect_ok(90, "R8 recovery"); send_sync(90, 0, 0, 0);

    hold(1'b1, 50);
    check(sb.size() == 0, "R3 results missing", sb.size(), 0);
    check(brk_seen == brk_exp, "R1 break count", brk_seen, brk_exp);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule